// File: doc/BRIEF.md
# Selectable-Polynomial Parallel PRBS Word Generator

This block produces a pseudo-random bit pattern for link testing, 64 bits per clock. At run time it picks one of four maximal-length polynomials (orders 9, 15, 23 and 31) through a one-hot select. Each polynomial has its own Fibonacci shift register. When a register is selected and generation is allowed, it moves forward 64 positions in a single cycle, and the 64 bits it generates appear on the output word.

Generation runs only when all of these hold: the test-mode field holds its enabling code, the generator clock-enable field holds its enabling code, the width-select bit asks for 64-bit words, and the polynomial select is a legal one-hot value. An invert control applies to the output. Its reset value of 0 inverts the pattern, and a 1 sends the pattern as generated. A soft-reset input puts every shift register back to its all-ones seed. As soon as soft reset is released and the configuration allows it, the pattern restarts from that seed.

Top module: `prbs_multi_gen`

## Requirements
- R1: `poly_sel` bit 0 selects x^9+x^5+1, bit 1 selects x^15+x^14+1, bit 2 selects x^23+x^18+1 and bit 3 selects x^31+x^28+1. Generated bit k follows b[k] = b[k-N] ^ b[k-T], where N is the order and T the middle tap, and the N bits before b[0] are all ones. Word w carries b[64w+i] on `data_out[i]`, so bit 0 is the earliest bit.
- R2: Generation runs only while `test_mode` equals 3'b100. Any other value gives `data_vld` = 0 on the next cycle.
- R3: Generation runs only while `gen_clk_en` equals 2'b01. Any other value gives `data_vld` = 0 on the next cycle.
- R4: Generation runs only while `width_sel` is 0, which selects 64-bit words. A 1 gives `data_vld` = 0 on the next cycle.
- R5: When `no_invert` = 0, `data_out` is the bitwise complement of the R1 word. When `no_invert` = 1, `data_out` is the R1 word unchanged.
- R6: If `poly_sel` has zero bits set or more than one bit set, then on the next cycle `data_vld` = 0 and `data_out` = 0.
- R7: While `soft_rst` = 1, every shift register is loaded with all ones, and on the next cycle `data_vld` = 0 and `data_out` = 0. The first valid word after release is word 0 of the selected sequence. No shift register ever holds all zeros.
- R8: A shift register moves forward exactly 64 steps in each cycle in which it is selected and running. In every other cycle it holds its state. Pausing, or switching to another polynomial and back, therefore resumes the sequence with the next unsent word.
- R9: Whenever `data_vld` = 0, `data_out` = 0.
- R10: While `rst_n` = 0, `data_vld` = 0, `data_out` = 0 and every shift register holds all ones.
- R11: If the run conditions hold at a rising clock edge, the matching word and `data_vld` = 1 appear immediately after that edge, a latency of one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous reseed, active high |
| poly_sel | input | 4 | One-hot polynomial select (order 9, 15, 23, 31 from bit 0) |
| test_mode | input | 3 | Test-mode field, 3'b100 enables generation |
| gen_clk_en | input | 2 | Generator clock-enable field, 2'b01 enables |
| width_sel | input | 1 | Word-width select, 0 = 64 bits |
| no_invert | input | 1 | 0 = complement the output, 1 = send as generated |
| data_out | output | 64 | Generated word, bit 0 earliest |
| data_vld | output | 1 | Word on `data_out` is valid |

## Verification
The assertions check the gating rules on every cycle: a bad select, a wrong test or clock-enable code, a wide width setting and a soft reset must each clear the output, and an idle output must read zero. They also confirm that a shift register never collapses to all zeros and that register state does not move in any cycle where no lane advances. The actual bit values cannot be checked that way. Only the bench's scenarios can show them: the four sequences against an independent recurrence, the complemented form, continuity across pauses and polynomial switches, and the restart from the seed after a soft reset.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int NUM_POLY = 4;
  localparam int WORD_W   = 64;
  localparam int SLOT_W   = 32;
  localparam logic [2:0] TEST_ON  = 3'b100;
  localparam logic [1:0] CLKEN_ON = 2'b01;

  function automatic int poly_order(input int idx);
    case (idx)
      0:       return 9;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int poly_tap(input int idx);
    case (idx)
      0:       return 5;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/prbs_gen_ctrl.sv
module prbs_gen_ctrl #(
  parameter int NUM_SEL = prbs_gen_pkg::NUM_POLY
) (
  input  logic [NUM_SEL-1:0] poly_sel,
  input  logic [2:0]         test_mode,
  input  logic [1:0]         gen_clk_en,
  input  logic               width_sel,
  input  logic               soft_rst,
  output logic               run,
  output logic [NUM_SEL-1:0] lane_adv
);
  logic sel_ok, mode_ok, clk_ok, width_ok;

  always_comb begin
    sel_ok   = $onehot(poly_sel);
    mode_ok  = (test_mode == prbs_gen_pkg::TEST_ON);
    clk_ok   = (gen_clk_en == prbs_gen_pkg::CLKEN_ON);
    width_ok = !width_sel;
    run      = sel_ok && mode_ok && clk_ok && width_ok && !soft_rst;
    lane_adv = run ? poly_sel : '0;
  end
endmodule

// File: rtl/prbs_lfsr_lane.sv
module prbs_lfsr_lane #(
  parameter int ORDER  = 9,
  parameter int TAP    = 5,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              advance,
  output logic [WORD_W-1:0] word,
  output logic [ORDER-1:0]  state
);
  // Bits produced by WORD_W Fibonacci steps from state s; bit 0 first.
  function automatic logic [WORD_W-1:0] emit_bits(input logic [ORDER-1:0] s);
    logic [ORDER-1:0]  r;
    logic [WORD_W-1:0] w;
    logic              fb;
    r = s;
    w = '0;
    for (int i = 0; i < WORD_W; i++) begin
      fb   = r[ORDER-1] ^ r[TAP-1];
      w[i] = fb;
      r    = {r[ORDER-2:0], fb};
    end
    return w;
  endfunction

  // State after WORD_W steps.
  function automatic logic [ORDER-1:0] jump(input logic [ORDER-1:0] s);
    logic [ORDER-1:0] r;
    logic             fb;
    r = s;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[ORDER-1] ^ r[TAP-1];
      r  = {r[ORDER-2:0], fb};
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= '1;
    else if (reseed)  state <= '1;
    else if (advance) state <= jump(state);
  end

  assign word = emit_bits(state);
endmodule

// File: rtl/prbs_multi_gen.sv
module prbs_multi_gen #(
  parameter int WORD_W   = prbs_gen_pkg::WORD_W,
  parameter int NUM_POLY = prbs_gen_pkg::NUM_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [3:0]        poly_sel,
  input  logic [2:0]        test_mode,
  input  logic [1:0]        gen_clk_en,
  input  logic              width_sel,
  input  logic              no_invert,
  output logic [WORD_W-1:0] data_out,
  output logic              data_vld
);
  localparam int SLOT_W = prbs_gen_pkg::SLOT_W;
  localparam int FLAT_W = SLOT_W * NUM_POLY;

  // Named internal events, observed by the bound checker.
  logic                run;
  logic [NUM_POLY-1:0] lane_adv;
  logic [NUM_POLY-1:0] lane_zero;
  logic [FLAT_W-1:0]   lfsr_flat;
  logic [WORD_W-1:0]   lane_word [NUM_POLY];
  logic [WORD_W-1:0]   sel_word;

  prbs_gen_ctrl #(.NUM_SEL(NUM_POLY)) u_ctrl (
    .poly_sel   (poly_sel[NUM_POLY-1:0]),
    .test_mode  (test_mode),
    .gen_clk_en (gen_clk_en),
    .width_sel  (width_sel),
    .soft_rst   (soft_rst),
    .run        (run),
    .lane_adv   (lane_adv)
  );

  for (genvar g = 0; g < NUM_POLY; g++) begin : g_lane
    localparam int ORD = prbs_gen_pkg::poly_order(g);
    localparam int TP  = prbs_gen_pkg::poly_tap(g);
    logic [ORD-1:0]    st;
    logic [WORD_W-1:0] wd;

    prbs_lfsr_lane #(.ORDER(ORD), .TAP(TP), .WORD_W(WORD_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .reseed  (soft_rst),
      .advance (lane_adv[g]),
      .word    (wd),
      .state   (st)
    );

    assign lane_word[g]                       = wd;
    assign lane_zero[g]                       = (st == '0);
    assign lfsr_flat[g*SLOT_W +: SLOT_W]      = {{(SLOT_W-ORD){1'b0}}, st};
  end

  always_comb begin
    sel_word = '0;
    for (int g = 0; g < NUM_POLY; g++)
      if (poly_sel[g]) sel_word = sel_word | lane_word[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      data_vld <= 1'b0;
    end else if (run) begin
      data_out <= no_invert ? sel_word : ~sel_word;
      data_vld <= 1'b1;
    end else begin
      data_out <= '0;
      data_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/prbs_multi_gen_chk.sv
module prbs_multi_gen_chk #(
  parameter int WORD_W   = 64,
  parameter int NUM_POLY = 4,
  parameter int FLAT_W   = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                soft_rst,
  input logic [3:0]          poly_sel,
  input logic [2:0]          test_mode,
  input logic [1:0]          gen_clk_en,
  input logic                width_sel,
  input logic                run,
  input logic [NUM_POLY-1:0] lane_adv,
  input logic [NUM_POLY-1:0] lane_zero,
  input logic [FLAT_W-1:0]   lfsr_flat,
  input logic [WORD_W-1:0]   data_out,
  input logic                data_vld
);
  assert_bad_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(poly_sel) |=> (!data_vld && data_out == '0));

  assert_test_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != 3'b100) |=> !data_vld);

  assert_clk_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_clk_en != 2'b01) |=> !data_vld);

  assert_width_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    width_sel |=> !data_vld);

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!data_vld && data_out == '0));

  assert_no_lockup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lane_zero == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_adv == '0 && !soft_rst) |=> $stable(lfsr_flat));

  assert_single_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_adv));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_vld |-> data_out == '0);

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> data_vld);
endmodule

bind prbs_multi_gen prbs_multi_gen_chk #(
  .WORD_W(WORD_W), .NUM_POLY(NUM_POLY), .FLAT_W(FLAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .poly_sel(poly_sel),
  .test_mode(test_mode), .gen_clk_en(gen_clk_en), .width_sel(width_sel),
  .run(run), .lane_adv(lane_adv), .lane_zero(lane_zero),
  .lfsr_flat(lfsr_flat), .data_out(data_out), .data_vld(data_vld)
);

// File: tb/prbs_multi_gen_tb.sv
`timescale 1ns/1ps
module prbs_multi_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [3:0]  poly_sel = 4'b0001;
  logic [2:0]  test_mode = 3'b000;
  logic [1:0]  gen_clk_en = 2'b00;
  logic        width_sel = 1'b0;
  logic        no_invert = 1'b0;
  logic [63:0] data_out;
  logic        data_vld;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prbs_multi_gen u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .poly_sel(poly_sel),
    .test_mode(test_mode), .gen_clk_en(gen_clk_en), .width_sel(width_sel),
    .no_invert(no_invert), .data_out(data_out), .data_vld(data_vld)
  );

  // Recurrence model: b[k] = b[k-N] ^ b[k-T], N seed bits of one.
  function automatic logic [63:0] model_word(input int n, input int t, input int w);
    bit seq [0:511];
    logic [63:0] r;
    for (int k = 0; k < n; k++) seq[k] = 1'b1;
    for (int k = 0; k < 64*(w+1); k++) seq[n+k] = seq[k] ^ seq[n+k-t];
    for (int i = 0; i < 64; i++) r[i] = seq[n+64*w+i];
    return r;
  endfunction

  function automatic int ord_of(input logic [3:0] s);
    case (s)
      4'b0001: return 9;  4'b0010: return 15;
      4'b0100: return 23; default: return 31;
    endcase
  endfunction

  function automatic int tap_of(input logic [3:0] s);
    case (s)
      4'b0001: return 5;  4'b0010: return 14;
      4'b0100: return 18; default: return 28;
    endcase
  endfunction

  function automatic logic [63:0] expect_word(input logic [3:0] s, input logic ni, input int w);
    logic [63:0] m;
    m = model_word(ord_of(s), tap_of(s), w);
    return ni ? m : ~m;
  endfunction

  task automatic check(input string tag, input logic [63:0] act_d, input logic act_v,
                       input logic [63:0] exp_d, input logic exp_v);
    checks++;
    if (act_d !== exp_d || act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: data=%h vld=%b expected data=%h vld=%b", tag, act_d, act_v, exp_d, exp_v);
    end
  endtask

  // Soft-reset pulse with a new configuration; returns at the negedge after release.
  task automatic restart(input logic [3:0] s, input logic [2:0] tm, input logic [1:0] ce,
                         input logic ws, input logic ni);
    @(negedge clk);
    soft_rst = 1'b1; poly_sel = s; test_mode = tm; gen_clk_en = ce;
    width_sel = ws; no_invert = ni;
    @(negedge clk);
    check("R7 cleared during soft reset", data_out, data_vld, 64'h0, 1'b0);
    soft_rst = 1'b0;
  endtask

  // Vector: {tag, poly_sel, test_mode, gen_clk_en, width_sel, no_invert, exp_vld}
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    {4'd1, 4'b0001, 3'b100, 2'b01, 1'b0, 1'b1, 1'b1},  // R1 order 9
    {4'd1, 4'b0010, 3'b100, 2'b01, 1'b0, 1'b1, 1'b1},  // R1 order 15
    {4'd1, 4'b0100, 3'b100, 2'b01, 1'b0, 1'b1, 1'b1},  // R1 order 23
    {4'd1, 4'b1000, 3'b100, 2'b01, 1'b0, 1'b1, 1'b1},  // R1 order 31
    {4'd5, 4'b0001, 3'b100, 2'b01, 1'b0, 1'b0, 1'b1},  // R5 inverted
    {4'd5, 4'b1000, 3'b100, 2'b01, 1'b0, 1'b0, 1'b1},  // R5 inverted
    {4'd2, 4'b0010, 3'b101, 2'b01, 1'b0, 1'b1, 1'b0},  // R2 wrong code
    {4'd2, 4'b0010, 3'b000, 2'b01, 1'b0, 1'b1, 1'b0},  // R2 off
    {4'd3, 4'b0100, 3'b100, 2'b11, 1'b0, 1'b1, 1'b0},  // R3 wrong code
    {4'd3, 4'b0100, 3'b100, 2'b00, 1'b0, 1'b1, 1'b0},  // R3 off
    {4'd4, 4'b0001, 3'b100, 2'b01, 1'b1, 1'b1, 1'b0},  // R4 wide width
    {4'd6, 4'b0000, 3'b100, 2'b01, 1'b0, 1'b1, 1'b0},  // R6 no bit
    {4'd6, 4'b0011, 3'b100, 2'b01, 1'b0, 1'b1, 1'b0}   // R6 two bits
  };

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: data=%h vld=%b expected data=done vld=done", data_out, data_vld);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: hard reset
    #12;
    check("R10 hard reset outputs", data_out, data_vld, 64'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk (R11 latency: word 0 right after first enabled edge)
    for (int v = 0; v < NV; v++) begin
      logic [3:0] tg, ps; logic [2:0] tm; logic [1:0] ce; logic ws, ni, ev;
      {tg, ps, tm, ce, ws, ni, ev} = VEC[v];
      restart(ps, tm, ce, ws, ni);
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        check($sformatf("R%0d/R11 vector %0d word %0d", tg, v, w), data_out, data_vld,
              ev ? expect_word(ps, ni, w) : 64'h0, ev);
      end
    end

    // R8/R9/R2: pause and resume continues the sequence
    restart(4'b0010, 3'b100, 2'b01, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 word0 before pause", data_out, data_vld, expect_word(4'b0010, 1'b1, 0), 1'b1);
    test_mode = 3'b000;
    @(negedge clk);
    check("R9 idle output zero", data_out, data_vld, 64'h0, 1'b0);
    @(negedge clk);
    check("R2 still paused", data_out, data_vld, 64'h0, 1'b0);
    test_mode = 3'b100;
    @(negedge clk);
    check("R8 word1 after pause", data_out, data_vld, expect_word(4'b0010, 1'b1, 1), 1'b1);

    // R8: switch lanes and back
    poly_sel = 4'b1000;
    @(negedge clk);
    check("R8 order-31 lane fresh", data_out, data_vld, expect_word(4'b1000, 1'b1, 0), 1'b1);
    poly_sel = 4'b0010;
    @(negedge clk);
    check("R8 order-15 resumes word2", data_out, data_vld, expect_word(4'b0010, 1'b1, 2), 1'b1);
    poly_sel = 4'b1000; no_invert = 1'b0;
    @(negedge clk);
    check("R8/R5 order-31 word1 inverted", data_out, data_vld, expect_word(4'b1000, 1'b0, 1), 1'b1);

    // R7: soft reset mid-run reseeds; next word is word 0 again
    restart(4'b1000, 3'b100, 2'b01, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 reseeded word0", data_out, data_vld, expect_word(4'b1000, 1'b1, 0), 1'b1);

    // R10: hard reset mid-run clears and reseeds
    rst_n = 1'b0;
    #1;
    check("R10 async clear", data_out, data_vld, 64'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 restart word0", data_out, data_vld, expect_word(4'b1000, 1'b1, 0), 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule